// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines and presents one combined interrupt line to a processor. Each line is latched into a status register. When the block is built, each line is set to latch either on a rising edge or while it is held high. A separate enable register selects which latched requests may reach the processor. A two-bit master control must be fully on before the combined output can assert.

Software controls the block over a simple 32-bit register bus that selects a word by its index. Software can set or clear enable bits without a read-modify-write, because each operation has its own write-one alias register. Latched requests are cleared by writing ones to an acknowledge register. A vector register returns the number of the lowest pending source, so the interrupt handler can branch straight to that source.

Top module: `irq_hub`

## Requirements
- R1: While reset is active, and in the cycle after it, the status, enable and master registers read zero and `irq_o` is low.
- R2: An input built as edge type (its `EDGE_MASK` bit is 1) sets its status bit once per 0-to-1 transition. An input that stays high does not set the bit again after it has been acknowledged.
- R3: An input built as level type (its `EDGE_MASK` bit is 0) sets its status bit on every clock edge at which it is high. The bit therefore reads 1 again right after an acknowledge while the input stays high.
- R4: A write to the acknowledge register (index 3) clears every status bit that is 1 in the write data. If a new request arrives in the same cycle as the acknowledge, the new request wins and the status bit stays set.
- R5: A write to the set-enable alias (index 4) sets the enable bits that are 1 in the write data and leaves all other enable bits unchanged.
- R6: A write to the clear-enable alias (index 5) clears the enable bits that are 1 in the write data and leaves all other enable bits unchanged.
- R7: The pending register (index 1) reads as the status register (index 0) bitwise ANDed with the enable register (index 2).
- R8: `irq_o` is high exactly when at least one pending bit is set and master register bits 0 and 1 are both 1.
- R9: The vector register (index 6) returns the index of the lowest-numbered pending bit. It returns 0xFFFFFFFF when no bit is pending.
- R10: Writes to indices 0, 1 and 6 have no effect. Reads of indices 3, 4 and 5 return zero.
- R11: A write to the master register (index 7) stores write-data bits 1:0, and a read of index 7 returns them in bits 1:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | N_SRC | Interrupt request lines |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier, valid with bus_sel |
| bus_idx | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx, combinational |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach is a request that arrives in the same clock edge as the acknowledge that would clear it. On an edge input this is a lone transition that could be lost. The bench raises the source line and writes the acknowledge within one cycle, then reads the status back. A second delicate case is a level line held high across an acknowledge. The bench holds the line high through the acknowledge and checks that the bit reads set again right away, while an edge line held high the same way stays cleared.

// File: rtl/irq_hub_pkg.sv
// Package: register word indices and bus width shared by the controller.
// Assumes the bus addresses 32-bit words by a 3-bit index.
package irq_hub_pkg;
    localparam int BUS_W = 32;
    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_STATUS  = 3'd0,
        IDX_PENDING = 3'd1,
        IDX_ENABLE  = 3'd2,
        IDX_ACK     = 3'd3,
        IDX_SETEN   = 3'd4,
        IDX_CLREN   = 3'd5,
        IDX_VECTOR  = 3'd6,
        IDX_MASTER  = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/irq_hub_capture.sv
// Module: turns each request line into a one-cycle set event.
// Edge lines fire on a 0-to-1 change seen against a registered copy.
// Level lines fire every cycle they are high. Inputs are assumed synchronous.
module irq_hub_capture #(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] evt_o
);
    logic [N_SRC-1:0] src_q;

    // Keep last-cycle copy of the request lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_line
        if (EDGE_MASK[i]) begin : g_edge
            // Rising transition only.
            assign evt_o[i] = src_i[i] & ~src_q[i];
        end else begin : g_level
            // Any cycle the line is held high.
            assign evt_o[i] = src_i[i];
        end
    end
endmodule

// File: rtl/irq_hub_vector.sv
// Module: finds the lowest set bit of the pending word.
// Returns all ones when no bit is set. Purely combinational.
module irq_hub_vector #(
    parameter int N_SRC = 32
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic [31:0]      vec_o
);
    // Scan from the top down so that the lowest set index is the one kept.
    always_comb begin
        vec_o = '1;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) vec_o = 32'(i);
        end
    end
endmodule

// File: rtl/irq_hub.sv
// Module: register-mapped interrupt controller top.
// Holds the status, enable and master registers, decodes bus writes,
// muxes read data and drives the combined interrupt output.
// Assumes single-cycle bus accesses and N_SRC <= 32.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_o
);
    logic [N_SRC-1:0] stat_q, en_q, pend_w, evt_w, wmask_w;
    logic [1:0]       mer_q;
    logic [31:0]      vec_w, stat_x, en_x, pend_x;
    logic             wr_w;

    assign wr_w    = bus_sel & bus_we;
    assign wmask_w = bus_wdata[N_SRC-1:0];

    irq_hub_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .evt_o (evt_w)
    );

    // Latch new events, clear acknowledged bits; a new event beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (wr_w && bus_idx == IDX_ACK) begin
            stat_q <= (stat_q & ~wmask_w) | evt_w;
        end else begin
            stat_q <= stat_q | evt_w;
        end
    end

    // Update enable bits through the set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_w && bus_idx == IDX_SETEN) begin
            en_q <= en_q | wmask_w;
        end else if (wr_w && bus_idx == IDX_CLREN) begin
            en_q <= en_q & ~wmask_w;
        end
    end

    // Store the two master control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mer_q <= 2'b00;
        else if (wr_w && bus_idx == IDX_MASTER) mer_q <= bus_wdata[1:0];
    end

    assign pend_w = stat_q & en_q;

    irq_hub_vector #(.N_SRC(N_SRC)) u_vec (
        .pend_i (pend_w),
        .vec_o  (vec_w)
    );

    // Zero-extend the source-wide registers to bus width.
    always_comb begin
        stat_x = '0; en_x = '0; pend_x = '0;
        stat_x[N_SRC-1:0] = stat_q;
        en_x[N_SRC-1:0]   = en_q;
        pend_x[N_SRC-1:0] = pend_w;
    end

    // Select read data by word index; alias registers read as zero.
    always_comb begin
        unique case (reg_idx_e'(bus_idx))
            IDX_STATUS:  bus_rdata = stat_x;
            IDX_PENDING: bus_rdata = pend_x;
            IDX_ENABLE:  bus_rdata = en_x;
            IDX_VECTOR:  bus_rdata = vec_w;
            IDX_MASTER:  bus_rdata = {30'd0, mer_q};
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_o = (|pend_w) & mer_q[0] & mer_q[1];
endmodule

// File: rtl/irq_hub_checker.sv
// Module: property checker for irq_hub, attached by bind below.
// Observes ports and the internal registers; drives nothing.
module irq_hub_checker #(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_i,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [2:0]       bus_idx,
    input logic [31:0]      bus_wdata,
    input logic             irq_o,
    input logic [N_SRC-1:0] stat_q,
    input logic [N_SRC-1:0] en_q,
    input logic [1:0]       mer_q,
    input logic [31:0]      vec_w
);
    localparam logic [N_SRC-1:0] LVL = ~EDGE_MASK[N_SRC-1:0];

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat_q == '0 && en_q == '0 && mer_q == 2'b00 && !irq_o));

    a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mer_q == 2'b11));

    a_r5_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_idx == 3'd4) |=>
        ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

    a_r6_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_idx == 3'd5) |=>
        ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

    a_r3_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & LVL) != '0) |=>
        ((stat_q & $past(src_i & LVL)) == $past(src_i & LVL)));

    a_r9_vector_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) == '0) |-> (vec_w == 32'hFFFF_FFFF));
endmodule

bind irq_hub irq_hub_checker #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .mer_q     (mer_q),
    .vec_w     (vec_w)
);

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
// Bench: table-driven walk of register traffic, then directed corner cases.
// Lines 0..7 are edge type, the rest are level type.
module irq_hub_bench;
    localparam int          N   = 32;
    localparam logic [31:0] EDG = 32'h0000_00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic        sel = 1'b0, we = 1'b0;
    logic [2:0]  idx = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_hub #(.N_SRC(N), .EDGE_MASK(EDG)) u_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_we(we),
        .bus_idx(idx), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [31:0] src;
        logic        wr;
        logic [2:0]  widx;
        logic [31:0] wd;
        logic [2:0]  ridx;
        logic [31:0] exp;
        logic        eirq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{32'h0,   1'b0, 3'd0, 32'h0,   3'd0, 32'h0,   1'b0, 8'd1},  // R1 status idle
        '{32'h0,   1'b1, 3'd7, 32'h3,   3'd7, 32'h3,   1'b0, 8'd11}, // R11 master on
        '{32'h1,   1'b0, 3'd0, 32'h0,   3'd0, 32'h1,   1'b0, 8'd2},  // R2 edge latch
        '{32'h1,   1'b0, 3'd0, 32'h0,   3'd1, 32'h0,   1'b0, 8'd7},  // R7 not enabled
        '{32'h1,   1'b1, 3'd4, 32'h1,   3'd1, 32'h1,   1'b1, 8'd5},  // R5 set enable
        '{32'h1,   1'b0, 3'd0, 32'h0,   3'd6, 32'h0,   1'b1, 8'd9},  // R9 vector 0
        '{32'h1,   1'b1, 3'd3, 32'h1,   3'd0, 32'h0,   1'b0, 8'd2},  // R2 held high, no relatch
        '{32'h0,   1'b0, 3'd0, 32'h0,   3'd0, 32'h0,   1'b0, 8'd2},  // R2 fall no event
        '{32'h100, 1'b1, 3'd4, 32'h100, 3'd2, 32'h101, 1'b1, 8'd5},  // R5 others kept
        '{32'h100, 1'b1, 3'd3, 32'h100, 3'd0, 32'h100, 1'b1, 8'd3},  // R3 level relatch
        '{32'h100, 1'b0, 3'd0, 32'h0,   3'd6, 32'h8,   1'b1, 8'd9},  // R9 vector 8
        '{32'h0,   1'b1, 3'd3, 32'h100, 3'd0, 32'h0,   1'b0, 8'd4},  // R4 ack clears
        '{32'h0,   1'b0, 3'd0, 32'h0,   3'd6, 32'hFFFF_FFFF, 1'b0, 8'd9}, // R9 none
        '{32'h30,  1'b1, 3'd4, 32'h30,  3'd6, 32'h4,   1'b1, 8'd9},  // R9 lowest of two
        '{32'h30,  1'b1, 3'd5, 32'h10,  3'd2, 32'h121, 1'b1, 8'd6},  // R6 clear one bit
        '{32'h30,  1'b0, 3'd0, 32'h0,   3'd6, 32'h5,   1'b1, 8'd9},  // R9 after clear
        '{32'h30,  1'b1, 3'd7, 32'h1,   3'd1, 32'h20,  1'b0, 8'd8},  // R8 one master bit
        '{32'h30,  1'b1, 3'd7, 32'h3,   3'd7, 32'h3,   1'b1, 8'd8},  // R8 both bits
        '{32'h30,  1'b1, 3'd0, 32'hFFFF_FFFF, 3'd0, 32'h30, 1'b1, 8'd10}, // R10 status RO
        '{32'h30,  1'b1, 3'd6, 32'h0,   3'd3, 32'h0,   1'b1, 8'd10}, // R10 ack reads 0
        '{32'h30,  1'b0, 3'd0, 32'h0,   3'd4, 32'h0,   1'b1, 8'd10}, // R10 set reads 0
        '{32'h30,  1'b1, 3'd3, 32'hFFFF_FFFF, 3'd0, 32'h0, 1'b0, 8'd4}, // R4 ack all
        '{32'h0,   1'b1, 3'd1, 32'hFFFF_FFFF, 3'd2, 32'h121, 1'b0, 8'd10} // R10 pending RO
    };

    // Compare read data and irq, logging one FAIL line on mismatch.
    task automatic check(input logic [2:0] ri, input logic [31:0] ex,
                         input logic ei, input string tag);
        idx = ri;
        #1;
        n_chk++;
        if (rdata !== ex || irq !== ei) begin
            n_bad++;
            $display("FAIL %s: idx %0d rdata %h irq %b, expected %h irq %b",
                     tag, ri, rdata, irq, ex, ei);
        end
    endtask

    // Drive one cycle of source lines and an optional write.
    task automatic cycle(input logic [31:0] s, input logic w,
                         input logic [2:0] wi, input logic [31:0] wd);
        @(negedge clk);
        src = s; sel = w; we = w; idx = wi; wdata = wd;
        @(posedge clk);
        #1;
        sel = 1'b0; we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            cycle(TBL[k].src, TBL[k].wr, TBL[k].widx, TBL[k].wd);
            check(TBL[k].ridx, TBL[k].exp, TBL[k].eirq,
                  $sformatf("R%0d entry %0d", TBL[k].req, k));
        end
        // R4: edge event on line 1 lands with its own acknowledge; set wins.
        cycle(32'h2, 1'b1, 3'd3, 32'h2);
        check(3'd0, 32'h2, 1'b0, "R4 set beats ack");
        cycle(32'h2, 1'b1, 3'd3, 32'h2);
        check(3'd0, 32'h0, 1'b0, "R4 plain ack");
        // R1: reset in the middle of activity.
        cycle(32'h100, 1'b1, 3'd7, 32'h3);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(3'd0, 32'h0, 1'b0, "R1 status after reset");
        check(3'd2, 32'h0, 1'b0, "R1 enable after reset");
        check(3'd7, 32'h0, 1'b0, "R1 master after reset");
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule